// File: doc/BRIEF.md
# Presettable Down-Counting Frequency Divider

This block is a 4-bit down counter meant for divide-by-N frequency division. A parameter chooses between decade counting (values 9 down to 0) and plain binary counting (15 down to 0). The counter steps down by one on a count event. A count event is either a rising edge of the count clock while the inhibit input is low, or a falling edge of inhibit while the count clock is high. This lets inhibit serve as a second count input that reacts to falling edges. A parallel load input with its own enable sets the count. A reset input clears the count and overrides everything else. A decoded zero flag goes high when the count is zero and the cascade input is high.

Count clock and inhibit are sampled by the system clock `clk`, and their edges are found from the sampled levels. The reset clears the count asynchronously. The load takes effect on the next system clock edge and repeats on every edge while the enable stays high, so it is independent of the count edges.

For a single-stage divider, the zero flag is wired back to the load enable, and the counter reloads N right after it reaches zero. For a multi-digit divider, each stage's cascade input is driven from the zero flag of the stage above it. All stages share one load enable, which is taken from the lowest stage's zero flag. A higher stage is inhibited except while the stage below it holds zero.

A small control state machine decides what the count does in each cycle. It has four states:
- ST_CLEAR is entered on reset.
- ST_LOAD is used while the load enable is high (transition "load").
- ST_HOLD is used while inhibit is high and no load is requested (transition "block").
- ST_RUN covers the remaining cases (transition "release").

The next state is chosen from the inputs in the same priority order from every state. A falling inhibit edge is recognised as the move from ST_HOLD to ST_RUN.

Top module: `down_divider`

## Requirements
- R1: A rising edge of `cnt_clk` while `cnt_inh` is low lowers `count_q` by exactly one. The new value is visible after the first `clk` edge that samples the new `cnt_clk` level. A falling edge of `cnt_clk` leaves the count unchanged.
- R2: A falling edge of `cnt_inh` while `cnt_clk` is high lowers `count_q` by one.
- R3: While `cnt_inh` is high, no `cnt_clk` edge changes the count. A rising edge of `cnt_inh`, and a falling edge of `cnt_inh` while `cnt_clk` is low, also leave the count unchanged.
- R4: A high `rst` clears `count_q` to 0 without waiting for a `clk` edge. While `rst` is high, the count stays 0 even when `load_en` is high.
- R5: While `load_en` is high and `rst` is low, each `clk` edge copies `load_val` into `count_q`, and count events are ignored. The loaded value stays after `load_en` falls.
- R6: `zero_o` is 1 exactly when `count_q` is 0 and `casc_in` is 1. It is 0 whenever `casc_in` is 0.
- R7: Stepping down from 0 gives 9 when BCD_MODE is 1 and 15 when BCD_MODE is 0.
- R8: With BCD_MODE set to 1, a loaded value above 9 counts down by one per event (12, 11, 10, 9, 8) and does not lock up.
- R9: Two decade stages chained as described in the overview, loaded with 3 (high digit) and 7 (low digit), raise the low stage's zero flag once every 37 count-clock pulses and reload to 3 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Asynchronous clear, active high, highest priority |
| cnt_clk | input | 1 | Count clock; its rising edge counts while inhibit is low |
| cnt_inh | input | 1 | Inhibit; a high level blocks counting, and its falling edge counts while `cnt_clk` is high |
| load_en | input | 1 | Parallel load enable, active high |
| load_val | input | CNT_W | Value to load |
| casc_in | input | 1 | Cascade input that gates the zero flag |
| count_q | output | CNT_W | Current count |
| zero_o | output | 1 | High when the count is zero and `casc_in` is high |

## Verification
The assertions assume that every input is synchronous to `clk` and changes between its edges. They also assume that each level of `cnt_clk` and `cnt_inh` lasts at least one system cycle, so that no edge of the count inputs is lost between samples. The bench changes inputs only on the falling edge of `clk`, keeps each count-clock level for one full system cycle, and drives `rst` a short time after a falling edge so that its asynchronous effect can be seen before the next rising edge. In the chained test, the count-clock pulses stay one cycle long. This keeps a clock level from overlapping the end of the higher stage's inhibit, because that overlap would count as an extra falling-inhibit event.

// File: rtl/dd_pkg.sv
package dd_pkg;

    // Control states of the divider
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } dd_state_e;

endpackage

// File: rtl/dd_clk_rise.sv
// Detects rising edges of the sampled count clock; the first cycle after
// reset is used only to capture a reference level.
module dd_clk_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic rise
);
    logic lvl_prev;
    logic primed;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            primed   <= 1'b0;
        end else begin
            lvl_prev <= lvl_in;
            primed   <= 1'b1;
        end
    end

    assign rise = primed & lvl_in & ~lvl_prev;
endmodule

// File: rtl/dd_step.sv
// Next-lower count value with the wrap chosen by the counting variant.
module dd_step #(
    parameter int CNT_W    = 4,
    parameter bit BCD_MODE = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] nxt
);
    generate
        if (BCD_MODE) begin : g_decade
            localparam logic [CNT_W-1:0] TOP = CNT_W'(9);
            assign nxt = (cur == '0) ? TOP : cur - 1'b1;
        end else begin : g_binary
            assign nxt = cur - 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dd_zero_detect.sv
// Decoded zero flag, gated by the cascade input.
module dd_zero_detect #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             casc,
    output logic             zero
);
    assign zero = casc & (cnt == '0);
endmodule

// File: rtl/down_divider.sv
module down_divider
    import dd_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter bit BCD_MODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clk,
    input  logic             cnt_inh,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             casc_in,
    output logic [CNT_W-1:0] count_q,
    output logic             zero_o
);
    dd_state_e        st_q;
    dd_state_e        st_d;
    logic             clk_rise;
    logic             step_now;
    logic [CNT_W-1:0] cnt_r;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] cnt_nxt;

    dd_clk_rise u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (cnt_clk),
        .rise   (clk_rise)
    );

    dd_step #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_step (
        .cur (cnt_r),
        .nxt (cnt_dec)
    );

    dd_zero_detect #(.CNT_W(CNT_W)) u_zero (
        .cnt  (cnt_r),
        .casc (casc_in),
        .zero (zero_o)
    );

    // Transitions: load, block, release (same priority from every state)
    always_comb begin
        if (load_en)      st_d = ST_LOAD;
        else if (cnt_inh) st_d = ST_HOLD;
        else              st_d = ST_RUN;
    end

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= ST_CLEAR;
        else     st_q <= st_d;
    end

    // Count action for the state being entered
    always_comb begin
        step_now = 1'b0;
        cnt_nxt  = cnt_r;
        unique case (st_d)
            ST_CLEAR: cnt_nxt = '0;
            ST_LOAD:  cnt_nxt = load_val;
            ST_HOLD:  cnt_nxt = cnt_r;
            ST_RUN: begin
                // clock rise with inhibit low, or inhibit release with clock high
                step_now = clk_rise | ((st_q == ST_HOLD) & cnt_clk);
                cnt_nxt  = step_now ? cnt_dec : cnt_r;
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_r <= '0;
        else     cnt_r <= cnt_nxt;
    end

    assign count_q = cnt_r;
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
    parameter int CNT_W    = 4,
    parameter bit BCD_MODE = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_inh,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic             casc_in,
    input logic [CNT_W-1:0] count_q,
    input logic             zero_o
);
    localparam logic [CNT_W-1:0] TOP = BCD_MODE ? CNT_W'(9) : {CNT_W{1'b1}};

    // R4
    always @(negedge clk) begin
        if (rst) begin
            rst_clear_chk: assert (count_q == '0);
        end
    end

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count_q == $past(load_val));

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cnt_inh) |=> $stable(count_q));

    // R6
    zero_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (casc_in && count_q == '0));

    // R6
    zero_present_chk: assert property (@(posedge clk) disable iff (rst)
        (casc_in && count_q == '0) |-> zero_o);

    // R7
    wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count_q == '0) |=> (count_q == '0 || count_q == TOP));

    // R1
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count_q != '0) |=>
            (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));
endmodule

bind down_divider dd_checker #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_dd_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_inh  (cnt_inh),
    .load_en  (load_en),
    .load_val (load_val),
    .casc_in  (casc_in),
    .count_q  (count_q),
    .zero_o   (zero_o)
);

// File: tb/test_down_divider.sv
`timescale 1ns/1ps
module test_down_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_clk = 1'b0;
    logic       cnt_inh = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic       casc = 1'b1;
    logic [3:0] count_q;
    logic       zero_o;
    logic [3:0] bin_q;
    logic       bin_zero;

    logic       ch_clk = 1'b0;
    logic       ch_load;
    logic       hi_inh;
    logic [3:0] hi_q;
    logic [3:0] lo_q;
    logic       hi_zero;
    logic       lo_zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    down_divider #(.CNT_W(4), .BCD_MODE(1'b1)) i_down_divider (
        .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .cnt_inh(cnt_inh),
        .load_en(load_en), .load_val(load_val), .casc_in(casc),
        .count_q(count_q), .zero_o(zero_o));

    down_divider #(.CNT_W(4), .BCD_MODE(1'b0)) i_bin (
        .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .cnt_inh(cnt_inh),
        .load_en(load_en), .load_val(load_val), .casc_in(1'b1),
        .count_q(bin_q), .zero_o(bin_zero));

    // Two-digit chain: high digit 3, low digit 7
    assign ch_load = lo_zero;
    assign hi_inh  = (lo_q != 4'd0);

    down_divider #(.CNT_W(4), .BCD_MODE(1'b1)) i_hi (
        .clk(clk), .rst(rst), .cnt_clk(ch_clk), .cnt_inh(hi_inh),
        .load_en(ch_load), .load_val(4'd3), .casc_in(1'b1),
        .count_q(hi_q), .zero_o(hi_zero));

    down_divider #(.CNT_W(4), .BCD_MODE(1'b1)) i_lo (
        .clk(clk), .rst(rst), .cnt_clk(ch_clk), .cnt_inh(1'b0),
        .load_en(ch_load), .load_val(4'd7), .casc_in(hi_zero),
        .count_q(lo_q), .zero_o(lo_zero));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_clk();
        cnt_clk = 1'b1;
        tick();
        cnt_clk = 1'b0;
        tick();
    endtask

    task automatic do_load(input logic [3:0] v);
        load_val = v;
        load_en  = 1'b1;
        tick();
        load_en  = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R4 count after reset", count_q, 0);
        chk("R6 zero with cascade high", zero_o, 1);
        casc = 1'b0;
        #1;
        chk("R6 zero with cascade low", zero_o, 0);
        tick();
        casc = 1'b1;
        tick();
    endtask

    task automatic t_load();
        load_val = 4'd7;
        load_en  = 1'b1;
        tick();
        chk("R5 load copies value", count_q, 7);
        pulse_clk();
        chk("R5 clock ignored during load", count_q, 7);
        load_en = 1'b0;
        tick();
        chk("R5 value kept after load", count_q, 7);
        chk("R6 zero low at nonzero count", zero_o, 0);
    endtask

    task automatic t_clock();
        pulse_clk();
        chk("R1 first clock step", count_q, 6);
        cnt_clk = 1'b1;
        tick();
        chk("R1 step on rising clock", count_q, 5);
        cnt_clk = 1'b0;
        tick();
        chk("R1 falling clock no step", count_q, 5);
        pulse_clk();
        chk("R1 third clock step", count_q, 4);
    endtask

    task automatic t_inhibit();
        cnt_inh = 1'b1;
        tick();
        pulse_clk();
        pulse_clk();
        chk("R3 clock blocked by inhibit", count_q, 4);
        cnt_inh = 1'b0;
        tick();
        chk("R3 inhibit fall with clock low", count_q, 4);
        cnt_inh = 1'b1;
        tick();
        chk("R3 inhibit rise no step", count_q, 4);
    endtask

    task automatic t_inh_clock();
        cnt_clk = 1'b1;
        tick();
        chk("R3 clock rise while inhibited", count_q, 4);
        cnt_inh = 1'b0;
        tick();
        chk("R2 inhibit fall with clock high", count_q, 3);
        cnt_clk = 1'b0;
        tick();
        cnt_inh = 1'b1;
        tick();
        cnt_clk = 1'b1;
        tick();
        cnt_inh = 1'b0;
        tick();
        chk("R2 second inhibit step", count_q, 2);
        cnt_clk = 1'b0;
        tick();
    endtask

    task automatic t_wrap();
        do_load(4'd0);
        chk("R7 decade at zero", count_q, 0);
        chk("R7 binary at zero", bin_q, 0);
        chk("R6 binary zero flag", bin_zero, 1);
        pulse_clk();
        chk("R7 decade wraps to 9", count_q, 9);
        chk("R7 binary wraps to 15", bin_q, 15);
        pulse_clk();
        chk("R7 decade after wrap", count_q, 8);
        chk("R7 binary after wrap", bin_q, 14);
    endtask

    task automatic t_bcd_over();
        do_load(4'd12);
        chk("R8 value above 9 loaded", count_q, 12);
        for (int k = 11; k >= 8; k--) begin
            pulse_clk();
            chk("R8 count from above 9", count_q, k);
        end
    endtask

    task automatic t_reset_prio();
        load_val = 4'd5;
        load_en  = 1'b1;
        tick();
        chk("R5 load before reset", count_q, 5);
        #2 rst = 1'b1;
        #1;
        chk("R4 asynchronous clear", count_q, 0);
        tick();
        chk("R4 reset over load", count_q, 0);
        rst     = 1'b0;
        load_en = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_chain();
        chk("R9 high digit loaded", hi_q, 3);
        chk("R9 low digit loaded", lo_q, 7);
        for (int run = 0; run < 2; run++) begin
            int  n;
            bit  seen;
            n    = 0;
            seen = 1'b0;
            while (!seen && n < 200) begin
                ch_clk = 1'b1;
                tick();
                n++;
                seen = lo_zero;
                if (n == 7) begin
                    chk("R6 low stage zero blocked by cascade", lo_zero, 0);
                end
                ch_clk = 1'b0;
                tick();
            end
            chk("R9 pulses per output", n, 37);
            chk("R9 high digit reload", hi_q, 3);
            chk("R9 low digit reload", lo_q, 7);
        end
    endtask

    initial begin
        t_reset();
        t_load();
        t_clock();
        t_inhibit();
        t_inh_clock();
        t_wrap();
        t_bcd_over();
        t_reset_prio();
        t_chain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule